// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small 2D drawing engine for a frame buffer of 8-bit pixels. It performs two operations: filling a rectangle with a solid colour, and copying a rectangle from one place on the screen to another. Software programs the geometry through a register bus, launches an operation by reading a launch register, and polls a status word until the engine is idle again. The frame buffer itself sits outside the block. The engine reaches it through a single pixel port that carries a per-bit write mask and returns read data one cycle after a read request.

A fill takes two corner pairs, both written through one absolute-rectangle Y/X register pair. The far corner is exclusive. A copy takes four inclusive vertices: the source top-left and bottom-right, then the destination top-left and bottom-right. The copy walks the rectangle in an order picked from where the destination sits relative to the source, so overlapping regions come out right. Every write is limited to a clip window and masked by a plane mask. Register writes that arrive while an operation runs are stalled on the bus until the engine goes idle.

Top module: `rect_engine`

## Requirements
- R1: After reset the engine is idle. The clip window reads back as min X = 0, min Y = 0, max X = XRES-1, max Y = YRES-1. reg_ready is high.
- R2: Register map (word addresses on reg_addr):
  - 0: status
  - 1: foreground colour
  - 2: plane mask
  - 3: fill launch
  - 4: copy launch
  - 5: rectangle Y
  - 6: rectangle X
  - 8 to 11: clip min X, min Y, max X, max Y
  - 16+2k: vertex k X, and 17+2k: vertex k Y, for k = 0..3

  Registers 1, 2 and 8 to 11 read back what was written.
- R3: Writing rectangle Y then X sets the first corner, and the next Y then X pair sets the far corner. A read of the fill launch register starts the fill. It writes the foreground colour to every pixel with x0 <= x < x1 and y0 <= y < y1, row by row from the top, each row left to right, at address y*XRES + x.
- R4: pix_wmask always equals the plane mask. Frame-buffer bits whose mask bit is clear keep their old value.
- R5: A read of the copy launch register starts the copy. Source is (X0,Y0)..(X1,Y1) and destination starts at (X2,Y2), all corners inclusive. The copied width is the smaller of X1-X0+1 and X3-X2+1, and the height is found the same way. Each destination pixel receives the value its source pixel held before the copy began.
- R6: A copy scans columns right to left when X2 > X0, and rows bottom to top when Y2 > Y0. Otherwise it scans left to right and top to bottom. Overlapping copies therefore give the same result as a non-overlapping copy.
- R7: Status bit 28 is 1 from the cycle after an accepted launch until the last pixel has been written.
- R8: A launch read returns 0 when the engine is idle. While the engine is busy it returns 32'hA000_0000 (bit 31 and bit 29 set) and the running operation is not disturbed.
- R9: A register write presented while the engine is busy sees reg_ready low and takes effect only after the engine is idle. An operation in progress keeps the colour and geometry it was launched with.
- R10: Pixels whose destination lies outside the inclusive clip window are not written.
- R11: A fill with x1 <= x0 or y1 <= y0, and a copy with either corner pair inverted, performs no pixel write and never sets the busy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read; a read of a launch register starts an operation |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Low while a write is stalled |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| pix_we | output | 1 | Pixel write strobe |
| pix_re | output | 1 | Pixel read strobe (copy source) |
| pix_addr | output | AW | Pixel address y*XRES+x |
| pix_wdata | output | 8 | Pixel write data |
| pix_wmask | output | 8 | Per-bit write mask |
| pix_rdata | input | 8 | Pixel read data, valid the cycle after pix_re |

## Verification
The bench uses the default 16 x 8 screen with 8-bit coordinates. At that size a full-screen fill takes 128 cycles, which leaves time to send launch reads and register writes while the engine is busy. At the same size, small overlapping copies reach all four relative placements of source and destination. The scoreboard predicts the exact order of the pixel writes, so a wrong scan direction is caught even when the final image happens to match. The 16-pixel row pitch also makes each address easy to check against x and y by hand.

// File: rtl/rect_engine.sv
module rect_engine #(
  parameter int CW   = 8,
  parameter int XRES = 16,
  parameter int YRES = 8,
  localparam int AW  = $clog2(XRES * YRES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic          reg_ready,
  output logic [31:0]   reg_rdata,
  output logic          pix_we,
  output logic          pix_re,
  output logic [AW-1:0] pix_addr,
  output logic [7:0]    pix_wdata,
  output logic [7:0]    pix_wmask,
  input  logic [7:0]    pix_rdata
);
  localparam logic [4:0] A_STAT = 5'd0, A_FG = 5'd1, A_PM = 5'd2, A_DRAW = 5'd3,
                         A_BLIT = 5'd4, A_RY = 5'd5, A_RX = 5'd6, A_CMINX = 5'd8,
                         A_CMINY = 5'd9, A_CMAXX = 5'd10, A_CMAXY = 5'd11;
  localparam int BUSY_BIT = 28;
  localparam logic [31:0] RETRY = 32'hA000_0000;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_CRD, S_CWR} st_t;
  st_t st;

  logic [7:0]    fg, pmask;
  logic [CW-1:0] cminx, cminy, cmaxx, cmaxy;
  logic [CW-1:0] fx0, fy0, fx1, fy1;
  logic          fph;
  logic [CW-1:0] vx [4];
  logic [CW-1:0] vy [4];
  logic [CW-1:0] bx, by, dx, dy, wm1, hm1, ox, oy;
  logic          rx, ry;

  wire busy        = (st != S_IDLE);
  wire wr_ok       = reg_wr && !busy;
  wire launch_fill = reg_rd && !busy && reg_addr == A_DRAW;
  wire launch_copy = reg_rd && !busy && reg_addr == A_BLIT;
  wire is_vert     = reg_addr[4] && !reg_addr[3];

  wire fill_empty = (fx1 <= fx0) || (fy1 <= fy0);
  wire copy_empty = (vx[1] < vx[0]) || (vy[1] < vy[0]) || (vx[3] < vx[2]) || (vy[3] < vy[2]);
  wire [CW-1:0] ws = vx[1] - vx[0], wd = vx[3] - vx[2];
  wire [CW-1:0] hs = vy[1] - vy[0], hd = vy[3] - vy[2];
  wire [CW-1:0] cwm1 = (ws < wd) ? ws : wd;
  wire [CW-1:0] chm1 = (hs < hd) ? hs : hd;

  wire [CW-1:0] colx = rx ? wm1 - ox : ox;
  wire [CW-1:0] rowy = ry ? hm1 - oy : oy;
  wire [CW-1:0] sxp = bx + colx, syp = by + rowy;
  wire [CW-1:0] dxp = dx + colx, dyp = dy + rowy;
  wire [AW-1:0] saddr = AW'(int'(syp) * XRES + int'(sxp));
  wire [AW-1:0] daddr = AW'(int'(dyp) * XRES + int'(dxp));
  wire inclip = (dxp >= cminx) && (dxp <= cmaxx) && (dyp >= cminy) && (dyp <= cmaxy);

  assign reg_ready = !(reg_wr && busy);
  assign pix_re    = (st == S_CRD);
  assign pix_we    = (st == S_FILL || st == S_CWR) && inclip;
  assign pix_addr  = pix_re ? saddr : daddr;
  assign pix_wdata = (st == S_FILL) ? fg : pix_rdata;
  assign pix_wmask = pmask;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT:  reg_rdata[BUSY_BIT] = busy;
      A_DRAW, A_BLIT: reg_rdata = busy ? RETRY : 32'd0;
      A_FG:    reg_rdata = {24'd0, fg};
      A_PM:    reg_rdata = {24'd0, pmask};
      A_CMINX: reg_rdata = 32'(cminx);
      A_CMINY: reg_rdata = 32'(cminy);
      A_CMAXX: reg_rdata = 32'(cmaxx);
      A_CMAXY: reg_rdata = 32'(cmaxy);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      fg <= '0; pmask <= '1;
      cminx <= '0; cminy <= '0;
      cmaxx <= CW'(XRES - 1); cmaxy <= CW'(YRES - 1);
      fx0 <= '0; fy0 <= '0; fx1 <= '0; fy1 <= '0; fph <= 1'b0;
      for (int k = 0; k < 4; k++) begin vx[k] <= '0; vy[k] <= '0; end
      bx <= '0; by <= '0; dx <= '0; dy <= '0;
      wm1 <= '0; hm1 <= '0; ox <= '0; oy <= '0; rx <= 1'b0; ry <= 1'b0;
    end else begin
      if (wr_ok) begin
        if (is_vert) begin
          if (reg_addr[0]) vy[reg_addr[2:1]] <= reg_wdata[CW-1:0];
          else             vx[reg_addr[2:1]] <= reg_wdata[CW-1:0];
        end
        case (reg_addr)
          A_FG:    fg    <= reg_wdata[7:0];
          A_PM:    pmask <= reg_wdata[7:0];
          A_CMINX: cminx <= reg_wdata[CW-1:0];
          A_CMINY: cminy <= reg_wdata[CW-1:0];
          A_CMAXX: cmaxx <= reg_wdata[CW-1:0];
          A_CMAXY: cmaxy <= reg_wdata[CW-1:0];
          A_RY: if (fph) fy1 <= reg_wdata[CW-1:0]; else fy0 <= reg_wdata[CW-1:0];
          A_RX: begin
            if (fph) fx1 <= reg_wdata[CW-1:0]; else fx0 <= reg_wdata[CW-1:0];
            fph <= !fph;
          end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: begin
          ox <= '0; oy <= '0;
          if (launch_fill) begin
            fph <= 1'b0;
            if (!fill_empty) begin
              bx <= fx0; by <= fy0; dx <= fx0; dy <= fy0;
              wm1 <= fx1 - fx0 - 1'b1; hm1 <= fy1 - fy0 - 1'b1;
              rx <= 1'b0; ry <= 1'b0;
              st <= S_FILL;
            end
          end else if (launch_copy && !copy_empty) begin
            bx <= vx[0]; by <= vy[0]; dx <= vx[2]; dy <= vy[2];
            wm1 <= cwm1; hm1 <= chm1;
            rx <= vx[2] > vx[0]; ry <= vy[2] > vy[0];
            st <= S_CRD;
          end
        end
        S_CRD: st <= S_CWR;
        default: begin
          if (ox == wm1) begin
            ox <= '0;
            if (oy == hm1) begin
              oy <= '0;
              st <= S_IDLE;
            end else begin
              oy <= oy + 1'b1;
              if (st == S_CWR) st <= S_CRD;
            end
          end else begin
            ox <= ox + 1'b1;
            if (st == S_CWR) st <= S_CRD;
          end
        end
      endcase
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fg) && $stable(pmask) && $stable(cmaxx)); // R9
  AST_START_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_rd)); // R3
  AST_RETRY_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_rd) |=> $stable(bx) && $stable(dx) && $stable(wm1) && busy || $past(ox == wm1 && oy == hm1)); // R8
  AST_EMPTY_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_fill && fill_empty) |=> !busy); // R11
  AST_COPY_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CWR) |-> $past(pix_re)); // R5
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_we && pix_re)); // R6
endmodule

// File: tb/rect_engine_tb.sv
`timescale 1ns/1ps
module rect_engine_tb;
  localparam int XRES = 16, YRES = 8, AW = 7, NPIX = XRES * YRES;
  localparam logic [4:0] A_STAT = 0, A_FG = 1, A_PM = 2, A_DRAW = 3, A_BLIT = 4,
                         A_RY = 5, A_RX = 6, A_CMINX = 8, A_CMINY = 9, A_CMAXX = 10, A_CMAXY = 11;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic reg_ready;
  logic [31:0] reg_rdata;
  logic pix_we, pix_re;
  logic [AW-1:0] pix_addr;
  logic [7:0] pix_wdata, pix_wmask, pix_rdata;

  always #2.5 clk = ~clk;

  rect_engine u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .pix_we(pix_we), .pix_re(pix_re), .pix_addr(pix_addr), .pix_wdata(pix_wdata),
    .pix_wmask(pix_wmask), .pix_rdata(pix_rdata));

  logic [7:0] mem [NPIX];
  logic [7:0] snap [NPIX];
  always @(posedge clk) begin
    if (pix_re) pix_rdata <= mem[pix_addr];
    if (pix_we) mem[pix_addr] <= (mem[pix_addr] & ~pix_wmask) | (pix_wdata & pix_wmask);
  end

  typedef struct packed { logic [AW-1:0] a; logic [7:0] d; logic [7:0] m; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  string cur_req = "R3";
  int cx0 = 0, cy0 = 0, cx1 = XRES - 1, cy1 = YRES - 1;
  logic [7:0] pm = 8'hFF;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pix_we) begin
      exp_t e;
      if (q.size() == 0) chk(0, cur_req, "unexpected pixel write at", pix_addr, 0);
      else begin
        e = q.pop_front();
        chk({pix_addr, pix_wdata, pix_wmask} == e, cur_req, "pixel write {addr,data,mask}",
            {pix_addr, pix_wdata, pix_wmask}, e);
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d, output bit held);
    held = 0;
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    forever begin
      #1;
      if (reg_ready) break;
      held = 1;
      @(negedge clk);
    end
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic w(logic [4:0] a, logic [31:0] d);
    bit h;
    wr(a, d, h);
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] s;
    int n = 0;
    do begin rd(A_STAT, s); n++; end while (s[28] && n < 3000);
    chk(!s[28], req, "engine idle", s, 0);
    chk(q.size() == 0, req, "expected writes left", q.size(), 0);
  endtask

  function automatic bit inclip(int x, int y);
    return x >= cx0 && x <= cx1 && y >= cy0 && y <= cy1;
  endfunction

  task automatic set_fill(int x0, int y0, int x1, int y1);
    w(A_RY, y0); w(A_RX, x0); w(A_RY, y1); w(A_RX, x1);
  endtask

  task automatic exp_fill(int x0, int y0, int x1, int y1, logic [7:0] c);
    for (int y = y0; y < y1; y++)
      for (int x = x0; x < x1; x++)
        if (inclip(x, y)) q.push_back({AW'(y * XRES + x), c, pm});
  endtask

  task automatic set_copy(int sx0, int sy0, int sx1, int sy1, int dx0, int dy0, int dx1, int dy1);
    w(17, sy0); w(16, sx0); w(19, sy1); w(18, sx1);
    w(21, dy0); w(20, dx0); w(23, dy1); w(22, dx1);
  endtask

  task automatic do_copy(string req, int sx0, int sy0, int sx1, int sy1, int dx0, int dy0, int dx1, int dy1);
    logic [7:0] sh [NPIX];
    logic [31:0] r;
    int wdt, hgt, bad;
    bit rvx, rvy;
    cur_req = req;
    set_copy(sx0, sy0, sx1, sy1, dx0, dy0, dx1, dy1);
    snap = mem; sh = mem;
    wdt = ((sx1 - sx0) < (dx1 - dx0) ? (sx1 - sx0) : (dx1 - dx0)) + 1;
    hgt = ((sy1 - sy0) < (dy1 - dy0) ? (sy1 - sy0) : (dy1 - dy0)) + 1;
    rvx = dx0 > sx0; rvy = dy0 > sy0;
    for (int j = 0; j < hgt; j++)
      for (int i = 0; i < wdt; i++) begin
        int c = rvx ? wdt - 1 - i : i;
        int rr = rvy ? hgt - 1 - j : j;
        int s = (sy0 + rr) * XRES + sx0 + c;
        int d = (dy0 + rr) * XRES + dx0 + c;
        if (inclip(dx0 + c, dy0 + rr)) begin
          q.push_back({AW'(d), sh[s], pm});
          sh[d] = sh[s];
        end
      end
    rd(A_BLIT, r);
    chk(r == 0, "R8", "launch read when idle", r, 0);
    wait_idle(req);
    bad = 0;
    for (int j = 0; j < hgt; j++)
      for (int i = 0; i < wdt; i++)
        if (mem[(dy0 + j) * XRES + dx0 + i] != snap[(sy0 + j) * XRES + sx0 + i]) bad++;
    chk(bad == 0, "R5", "destination pixels differing from original source", bad, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", "run did not finish", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit held;
    for (int i = 0; i < NPIX; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_STAT, r);  chk(r == 0, "R1", "status after reset", r, 0);
    rd(A_CMINX, r); chk(r == 0, "R1", "clip min x", r, 0);
    rd(A_CMINY, r); chk(r == 0, "R1", "clip min y", r, 0);
    rd(A_CMAXX, r); chk(r == XRES - 1, "R1", "clip max x", r, XRES - 1);
    rd(A_CMAXY, r); chk(r == YRES - 1, "R1", "clip max y", r, YRES - 1);
    chk(reg_ready, "R1", "reg_ready idle", reg_ready, 1);

    // R2 readback, R3 basic fill, R7 busy flag
    w(A_FG, 8'h5A); w(A_PM, 8'hFF);
    rd(A_FG, r); chk(r == 8'h5A, "R2", "colour readback", r, 8'h5A);
    cur_req = "R3";
    set_fill(2, 1, 5, 3);
    exp_fill(2, 1, 5, 3, 8'h5A);
    rd(A_DRAW, r); chk(r == 0, "R8", "fill launch idle", r, 0);
    rd(A_STAT, r); chk(r[28], "R7", "busy bit during fill", r[28], 1);
    wait_idle("R3");
    chk(mem[2 * XRES + 4] == 8'h5A, "R3", "filled pixel", mem[2 * XRES + 4], 8'h5A);
    chk(mem[1 * XRES + 5] == 8'(XRES + 5), "R3", "exclusive far corner untouched",
        mem[1 * XRES + 5], XRES + 5);

    // R8 retry while busy, R9 write held
    w(A_FG, 8'h11);
    cur_req = "R9";
    set_fill(0, 0, XRES, YRES);
    exp_fill(0, 0, XRES, YRES, 8'h11);
    rd(A_DRAW, r);
    rd(A_DRAW, r); chk(r == 32'hA000_0000, "R8", "fill launch while busy", r, 32'hA000_0000);
    rd(A_BLIT, r); chk(r == 32'hA000_0000, "R8", "copy launch while busy", r, 32'hA000_0000);
    wr(A_FG, 8'h22, held);
    chk(held, "R9", "write stalled while busy", held, 1);
    rd(A_FG, r); chk(r == 8'h22, "R9", "stalled write applied after idle", r, 8'h22);
    wait_idle("R9");

    // R4 plane mask
    cur_req = "R4";
    w(A_FG, 8'hA5); w(A_PM, 8'h0F); pm = 8'h0F;
    set_fill(0, 0, 2, 1);
    exp_fill(0, 0, 2, 1, 8'hA5);
    rd(A_DRAW, r);
    wait_idle("R4");
    chk(mem[1] == 8'h15, "R4", "masked pixel", mem[1], 8'h15);
    w(A_PM, 8'hFF); pm = 8'hFF;

    // R10 clip window
    cur_req = "R10";
    w(A_CMINX, 3); w(A_CMAXX, 4); w(A_CMINY, 0); w(A_CMAXY, 6);
    cx0 = 3; cx1 = 4; cy0 = 0; cy1 = 6;
    w(A_FG, 8'h33);
    set_fill(1, 5, 7, 8);
    exp_fill(1, 5, 7, 8, 8'h33);
    rd(A_DRAW, r);
    wait_idle("R10");
    chk(mem[5 * XRES + 2] == 8'h11, "R10", "pixel left of window", mem[5 * XRES + 2], 8'h11);
    chk(mem[7 * XRES + 3] == 8'h11, "R10", "pixel below window", mem[7 * XRES + 3], 8'h11);
    w(A_CMINX, 0); w(A_CMAXX, XRES - 1); w(A_CMAXY, YRES - 1);
    cx0 = 0; cx1 = XRES - 1; cy1 = YRES - 1;

    // R11 empty and inverted rectangles
    cur_req = "R11";
    set_fill(4, 4, 4, 6);
    rd(A_DRAW, r); chk(r == 0, "R11", "zero-width launch", r, 0);
    rd(A_STAT, r); chk(!r[28], "R11", "busy after zero-width", r[28], 0);
    set_fill(6, 2, 3, 5);
    rd(A_DRAW, r);
    rd(A_STAT, r); chk(!r[28], "R11", "busy after inverted fill", r[28], 0);
    set_copy(5, 5, 2, 6, 0, 0, 3, 1);
    rd(A_BLIT, r);
    rd(A_STAT, r); chk(!r[28], "R11", "busy after inverted copy", r[28], 0);
    chk(q.size() == 0, "R11", "queue after empty ops", q.size(), 0);

    // R5 / R6 copies
    for (int i = 0; i < NPIX; i++) mem[i] = 8'(i * 7 + 3);
    do_copy("R5", 0, 0, 3, 1, 8, 4, 11, 5);
    do_copy("R6", 2, 2, 7, 2, 4, 2, 9, 2);
    do_copy("R6", 5, 1, 8, 4, 3, 3, 6, 6);
    do_copy("R6", 4, 4, 7, 6, 2, 2, 5, 4);
    do_copy("R6", 1, 3, 4, 5, 3, 4, 6, 6);
    do_copy("R5", 0, 0, 5, 0, 0, 6, 2, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule